// File: doc/BRIEF.md
# Dual Configuration Bank with Context Switch

This block holds two complete copies of the configuration state that a content-addressable memory engine reads on every operation. Each copy has a control word, a segment-control word, a memory address pointer, a compare mask and a persistent source/destination selector. Only one copy is active at a time. The active copy is the one presented on the output pins and the one that memory reads, writes, moves and compares use.

A single command flips the active copy. A typical use is to keep one copy ready for filtering traffic and the other for table upkeep. The flip also clears the held match status, because a match result from one context means nothing in the other.

The address pointer of each copy can be loaded directly. The two low bits of its control word set how it moves: hold, step up or step down by one after each memory access. This lets a sequence of accesses walk through the table without reloading the pointer. The pointer wraps around at the ends of the memory.

Commands arrive on a valid/ready channel. A command transfers only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever reset is low, so the block never applies back-pressure in operation. When `cmd_valid` is low, the opcode and data pins are ignored. The match result and access strobes are plain single-cycle pulses.

Top module: `cfg_dual_bank`

## Requirements
- R1: After reset, set 0 is active, every register of both sets reads zero, `match_flag` is low and `cmd_ready` is high.
- R2: An accepted command with `cmd_op` 0, 1, 2, 3 or 4 writes `cmd_data` into the active set's control, segment, address (low ADDR_W bits), mask or source/destination register respectively. The new value appears on the `act_*` outputs in the cycle after the transfer.
- R3: An accepted command with `cmd_op` 5 toggles `act_sel`. From the next cycle, the `act_*` outputs show the other set's registers.
- R4: Writes and address steps never change the inactive set. Its values are the same when it becomes active again.
- R5: A swap clears `match_flag` on the next cycle. This holds even if a compare result arrives in the same cycle.
- R6: When `match_valid` is high and no swap is taken, `match_flag` takes the value of `match_hit` on the next cycle. Otherwise `match_flag` holds its value.
- R7: Control bits [1:0] of the active set select the address mode: 00 hold, 01 increment, 10 decrement, 11 hold. The active address changes on the clock edge that samples `mem_access` high.
- R8: Incrementing from DEPTH-1 gives 0. Decrementing from 0 gives DEPTH-1.
- R9: An address-load command in the same cycle as `mem_access` loads the commanded value, and the step is dropped.
- R10: A `mem_access` in the same cycle as a swap steps the address of the set that was active in that cycle, not the newly active set.
- R11: A command is taken only when `cmd_valid` and `cmd_ready` are both high. With `cmd_valid` low, and for `cmd_op` 6 or 7, no register and no selection changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Command opcode (see R2, R3, R11) |
| cmd_data | input | DATA_W | Register write value |
| mem_access | input | 1 | One memory access used the active address this cycle |
| match_valid | input | 1 | A compare result is present |
| match_hit | input | 1 | Compare result, 1 = match |
| act_sel | output | 1 | Index of the active set |
| act_ctrl | output | DATA_W | Active control register |
| act_seg | output | DATA_W | Active segment-control register |
| act_addr | output | ADDR_W | Active address pointer |
| act_mask | output | DATA_W | Active compare mask |
| act_psd | output | DATA_W | Active source/destination selector |
| match_flag | output | 1 | Held match status |

## Verification
Every register drives an output pin with no logic in between, so a wrong write or a wrong step shows on `act_*` one cycle after the command or access that caused it. Damage to the inactive set stays hidden until the next swap. The bench therefore changes one set, swaps, and reads the other set back. A wrong selection pointer shows as swapped values on all five register outputs at once. A failed match clear shows on `match_flag` in the cycle right after the swap.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int NUM_SETS = 2;

  typedef enum logic [2:0] {
    OP_CTRL = 3'd0,
    OP_SEG  = 3'd1,
    OP_ADDR = 3'd2,
    OP_MASK = 3'd3,
    OP_PSD  = 3'd4,
    OP_SWAP = 3'd5
  } cmd_op_e;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_INC  = 2'b01,
    AM_DEC  = 2'b10,
    AM_KEEP = 2'b11
  } addr_mode_e;

  typedef struct packed {
    logic ctrl;
    logic seg;
    logic addr;
    logic mask;
    logic psd;
  } wr_strobe_t;

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfgbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       cmd_ready,
  input  logic [2:0] cmd_op,
  output wr_strobe_t wr,
  output logic       swap
);

  logic take;
  assign take = cmd_valid && cmd_ready;

  always_comb begin
    wr   = '0;
    swap = 1'b0;
    if (take) begin
      case (cmd_op)
        OP_CTRL: wr.ctrl = 1'b1;
        OP_SEG:  wr.seg  = 1'b1;
        OP_ADDR: wr.addr = 1'b1;
        OP_MASK: wr.mask = 1'b1;
        OP_PSD:  wr.psd  = 1'b1;
        OP_SWAP: swap    = 1'b1;
        default: ;
      endcase
    end
  end

  assert_single_action_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr, swap}));

  assert_no_action_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |-> (wr == '0) && !swap);

endmodule

// File: rtl/cfg_active_sel.sv
module cfg_active_sel (
  input  logic clk,
  input  logic rst,
  input  logic swap,
  input  logic match_valid,
  input  logic match_hit,
  output logic sel,
  output logic match_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (swap) begin
        sel        <= ~sel;
        match_flag <= 1'b0;
      end else if (match_valid) begin
        match_flag <= match_hit;
      end
    end
  end

  assert_swap_toggles_R3: assert property (@(posedge clk) disable iff (rst)
    swap |=> sel != $past(sel));

  assert_sel_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(sel));

  assert_swap_clears_match_R5: assert property (@(posedge clk) disable iff (rst)
    swap |=> !match_flag);

  assert_match_load_R6: assert property (@(posedge clk) disable iff (rst)
    match_valid && !swap |=> match_flag == $past(match_hit));

  assert_match_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !match_valid && !swap |=> $stable(match_flag));

endmodule

// File: rtl/cfg_bank_set.sv
module cfg_bank_set
  import cfgbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_act,
  input  wr_strobe_t        wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              access,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] seg_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] psd_q
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  addr_mode_e        mode;
  logic [ADDR_W-1:0] addr_step;

  assign mode = addr_mode_e'(ctrl_q[1:0]);

  always_comb begin
    case (mode)
      AM_INC:  addr_step = (addr_q == LAST) ? '0 : addr_q + 1'b1;
      AM_DEC:  addr_step = (addr_q == '0) ? LAST : addr_q - 1'b1;
      default: addr_step = addr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      seg_q  <= '0;
      addr_q <= '0;
      mask_q <= '0;
      psd_q  <= '0;
    end else if (is_act) begin
      if (wr.ctrl) ctrl_q <= wdata;
      if (wr.seg)  seg_q  <= wdata;
      if (wr.mask) mask_q <= wdata;
      if (wr.psd)  psd_q  <= wdata;
      if (wr.addr)      addr_q <= wdata[ADDR_W-1:0];
      else if (access)  addr_q <= addr_step;
    end
  end

  assert_idle_set_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    !is_act |=> $stable(ctrl_q) && $stable(seg_q) && $stable(addr_q)
                && $stable(mask_q) && $stable(psd_q));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    is_act && wr.addr |=> addr_q == $past(wdata[ADDR_W-1:0]));

  assert_inc_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    is_act && access && !wr.addr && (mode == AM_INC) && (addr_q == LAST)
    |=> addr_q == '0);

  assert_dec_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    is_act && access && !wr.addr && (mode == AM_DEC) && (addr_q == '0)
    |=> addr_q == LAST);

  assert_dec_step_R7: assert property (@(posedge clk) disable iff (rst)
    is_act && access && !wr.addr && (mode == AM_DEC) && (addr_q != '0)
    |=> addr_q == $past(addr_q) - 1'b1);

  assert_hold_mode_R7: assert property (@(posedge clk) disable iff (rst)
    is_act && !wr.addr && ((mode == AM_HOLD) || (mode == AM_KEEP))
    |=> $stable(addr_q));

endmodule

// File: rtl/cfg_dual_bank.sv
module cfg_dual_bank
  import cfgbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              mem_access,
  input  logic              match_valid,
  input  logic              match_hit,
  output logic              act_sel,
  output logic [DATA_W-1:0] act_ctrl,
  output logic [DATA_W-1:0] act_seg,
  output logic [ADDR_W-1:0] act_addr,
  output logic [DATA_W-1:0] act_mask,
  output logic [DATA_W-1:0] act_psd,
  output logic              match_flag
);

  wr_strobe_t        wr;
  logic              swap;
  logic              sel;
  logic [DATA_W-1:0] ctrl_a [NUM_SETS];
  logic [DATA_W-1:0] seg_a  [NUM_SETS];
  logic [ADDR_W-1:0] addr_a [NUM_SETS];
  logic [DATA_W-1:0] mask_a [NUM_SETS];
  logic [DATA_W-1:0] psd_a  [NUM_SETS];

  assign cmd_ready = !rst;

  cfg_cmd_decode u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .wr        (wr),
    .swap      (swap)
  );

  cfg_active_sel u_sel (
    .clk         (clk),
    .rst         (rst),
    .swap        (swap),
    .match_valid (match_valid),
    .match_hit   (match_hit),
    .sel         (sel),
    .match_flag  (match_flag)
  );

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    cfg_bank_set #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
    ) u_set (
      .clk    (clk),
      .rst    (rst),
      .is_act (sel == 1'(g)),
      .wr     (wr),
      .wdata  (cmd_data),
      .access (mem_access),
      .ctrl_q (ctrl_a[g]),
      .seg_q  (seg_a[g]),
      .addr_q (addr_a[g]),
      .mask_q (mask_a[g]),
      .psd_q  (psd_a[g])
    );
  end

  assign act_sel  = sel;
  assign act_ctrl = ctrl_a[sel];
  assign act_seg  = seg_a[sel];
  assign act_addr = addr_a[sel];
  assign act_mask = mask_a[sel];
  assign act_psd  = psd_a[sel];

  assert_ready_out_of_reset_R1: assert property (@(posedge clk)
    !rst |-> cmd_ready);

  assert_access_outgoing_set_R10: assert property (@(posedge clk) disable iff (rst)
    swap && !mem_access |=> $stable(addr_a[0]) && $stable(addr_a[1]));

endmodule

// File: tb/tb_cfg_dual_bank.sv
module tb_cfg_dual_bank;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [2:0]        cmd_op = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic              mem_access = 1'b0;
  logic              match_valid = 1'b0;
  logic              match_hit = 1'b0;
  logic              act_sel;
  logic [DATA_W-1:0] act_ctrl, act_seg, act_mask, act_psd;
  logic [ADDR_W-1:0] act_addr;
  logic              match_flag;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_sel = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_dual_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .mem_access(mem_access),
    .match_valid(match_valid), .match_hit(match_hit), .act_sel(act_sel),
    .act_ctrl(act_ctrl), .act_seg(act_seg), .act_addr(act_addr),
    .act_mask(act_mask), .act_psd(act_psd), .match_flag(match_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int d, input bit acc, input bit mv, input bit mh);
    cmd_valid   = 1'b1;
    cmd_op      = op;
    cmd_data    = DATA_W'(d);
    mem_access  = acc;
    match_valid = mv;
    match_hit   = mh;
    @(negedge clk);
    cmd_valid   = 1'b0;
    mem_access  = 1'b0;
    match_valid = 1'b0;
    match_hit   = 1'b0;
    if (op == 3'd5) exp_sel ^= 1;
  endtask

  task automatic wr(input logic [2:0] op, input int d);
    cmd(op, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic access(input int n);
    for (int i = 0; i < n; i++) begin
      mem_access = 1'b1;
      @(negedge clk);
      mem_access = 1'b0;
    end
  endtask

  task automatic compare(input bit hit);
    match_valid = 1'b1;
    match_hit   = hit;
    @(negedge clk);
    match_valid = 1'b0;
    match_hit   = 1'b0;
  endtask

  task automatic to_set0();
    if (exp_sel != 0) wr(3'd5, 0);
  endtask

  task automatic t_reset();
    chk("R1 sel", act_sel, 0);
    chk("R1 ctrl", act_ctrl, 0);
    chk("R1 seg", act_seg, 0);
    chk("R1 addr", act_addr, 0);
    chk("R1 mask", act_mask, 0);
    chk("R1 psd", act_psd, 0);
    chk("R1 match", match_flag, 0);
    chk("R1 ready", cmd_ready, 1);
  endtask

  task automatic t_write_active();
    wr(3'd0, 'h1234);
    wr(3'd1, 'h00A5);
    wr(3'd3, 'hFF00);
    wr(3'd4, 'h0033);
    wr(3'd2, 5);
    chk("R2 ctrl", act_ctrl, 'h1234);
    chk("R2 seg", act_seg, 'h00A5);
    chk("R2 mask", act_mask, 'hFF00);
    chk("R2 psd", act_psd, 'h0033);
    chk("R2 addr", act_addr, 5);
  endtask

  task automatic t_swap();
    wr(3'd5, 0);
    chk("R3 sel", act_sel, 1);
    chk("R3 ctrl set1", act_ctrl, 0);
    chk("R3 mask set1", act_mask, 0);
    chk("R3 addr set1", act_addr, 0);
    wr(3'd3, 'h0F0F);
    wr(3'd1, 'h5A5A);
    wr(3'd5, 0);
    chk("R4 sel back", act_sel, 0);
    chk("R4 mask set0 kept", act_mask, 'hFF00);
    chk("R4 seg set0 kept", act_seg, 'h00A5);
    chk("R4 addr set0 kept", act_addr, 5);
    wr(3'd5, 0);
    chk("R4 mask set1 kept", act_mask, 'h0F0F);
    chk("R4 seg set1 kept", act_seg, 'h5A5A);
    to_set0();
  endtask

  task automatic t_match();
    compare(1'b1);
    chk("R6 hit", match_flag, 1);
    @(negedge clk);
    chk("R6 hold", match_flag, 1);
    compare(1'b0);
    chk("R6 miss", match_flag, 0);
    compare(1'b1);
    chk("R6 hit again", match_flag, 1);
    wr(3'd5, 0);
    chk("R5 swap clears", match_flag, 0);
    chk("R3 sel after swap", act_sel, exp_sel);
    compare(1'b1);
    chk("R6 hit set1", match_flag, 1);
    cmd(3'd5, 0, 1'b0, 1'b1, 1'b1);
    chk("R5 swap beats hit", match_flag, 0);
    to_set0();
  endtask

  task automatic t_addr_modes();
    wr(3'd0, 'h0001);
    wr(3'd2, 10);
    access(3);
    chk("R7 inc", act_addr, 13);
    wr(3'd0, 'h0002);
    access(2);
    chk("R7 dec", act_addr, 11);
    wr(3'd0, 'h0000);
    access(2);
    chk("R7 hold 00", act_addr, 11);
    wr(3'd0, 'h0003);
    access(1);
    chk("R7 hold 11", act_addr, 11);
  endtask

  task automatic t_wrap();
    wr(3'd0, 'h0001);
    wr(3'd2, DEPTH - 1);
    access(1);
    chk("R8 inc wrap", act_addr, 0);
    wr(3'd0, 'h0002);
    access(1);
    chk("R8 dec wrap", act_addr, DEPTH - 1);
  endtask

  task automatic t_load_prio();
    wr(3'd0, 'h0001);
    cmd(3'd2, 50, 1'b1, 1'b0, 1'b0);
    chk("R9 load beats step", act_addr, 50);
  endtask

  task automatic t_swap_access();
    wr(3'd0, 'h0001);
    wr(3'd2, 200);
    wr(3'd5, 0);
    wr(3'd0, 'h0001);
    wr(3'd2, 7);
    wr(3'd5, 0);
    cmd(3'd5, 0, 1'b1, 1'b0, 1'b0);
    chk("R10 sel", act_sel, 1);
    chk("R10 new set untouched", act_addr, 7);
    wr(3'd5, 0);
    chk("R10 old set stepped", act_addr, 201);
  endtask

  task automatic t_handshake();
    wr(3'd3, 'h1111);
    cmd_valid = 1'b0;
    cmd_op    = 3'd3;
    cmd_data  = 16'h2222;
    @(negedge clk);
    chk("R11 valid low mask", act_mask, 'h1111);
    cmd_op = 3'd5;
    @(negedge clk);
    chk("R11 valid low sel", act_sel, 0);
    wr(3'd6, 'h3333);
    wr(3'd7, 'h4444);
    chk("R11 op6/7 mask", act_mask, 'h1111);
    chk("R11 op6/7 ctrl", act_ctrl, 'h0001);
    chk("R11 op6/7 sel", act_sel, 0);
    chk("R11 ready", cmd_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_active();
    t_swap();
    t_match();
    t_addr_modes();
    t_wrap();
    t_load_prio();
    t_swap_access();
    t_handshake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule